// File: doc/BRIEF.md
# CSR State-Enable Access Gate

This combinational block decides whether a CSR access instruction may proceed or must trap, on a core that supports a hypervisor. It takes the decoded CSR address, the write flag, and the current privilege level with the virtualization bit. It also takes the low words of the machine, hypervisor and supervisor state-enable registers and a set of extension enables. From these it produces an illegal-instruction flag, a virtual-instruction flag and an exception cause code. The CSR storage itself lives elsewhere.

The gates run in a fixed order. First come the floating-point CSR checks. Next are the state-enable gates for the environment-configuration and hypervisor state-enable CSRs. A generic privilege and read-only check comes last. The first gate that fires sets the outcome. Whether a missing enable bit is reported as illegal or as virtual depends on the virtualization bit and on which gate caught the access.

Top module: `csr_se_gate`

## Requirements
- R1: An access to fflags (0x001), frm (0x002) or fcsr (0x003) with the floating-point extension disabled raises illegal instruction (cause 2), at any privilege level.
- R2: The state-enable gates for the floating-point CSRs apply only when both the state-enable extension and the FP-in-integer-registers extension are enabled; otherwise a floating-point CSR access with F enabled does not trap.
- R3: With floating-point gating active, a floating-point CSR access below M (privilege U=0, S=1, M=3) with machine state-enable bit 1 clear raises illegal instruction, whatever V and the other enable words hold.
- R4: With floating-point gating active and the machine check passed, V=1 with hypervisor state-enable bit 1 clear raises virtual instruction (cause 22).
- R5: With floating-point gating active and the earlier checks passed, supervisor implemented, privilege U and supervisor state-enable bit 1 clear, the access raises virtual instruction if V=1 and illegal instruction if V=0; without supervisor support, or at S or above, this check does not fire.
- R6: For senvcfg (0x10A) with the state-enable extension on, below M with machine bit 62 clear raises illegal; otherwise V=1 with hypervisor bit 62 clear raises virtual. With the extension off these gates do not fire.
- R7: For henvcfg (0x60A) with the state-enable extension on, below M with machine bit 62 clear raises illegal; hypervisor bit 62 is not consulted.
- R8: For hstateen0 (0x60C), below M with machine bit 63 clear raises illegal instruction, independent of the state-enable extension flag and of V.
- R9: State-enable gates take priority over the generic check, so an access from VU to senvcfg, henvcfg or hstateen0 with the machine bit clear reports illegal, not virtual.
- R10: Generic check: address bits [9:8] give the minimum level. A hypervisor-level CSR (level 2) needs M, or S with V=0; an access to it with V=1 that falls short raises virtual. Any other shortfall raises illegal.
- R11: A write to an address whose bits [11:10] equal 3 raises illegal instruction; a read of such an address with sufficient privilege does not trap.
- R12: At privilege M with V=0, no state-enable bit causes a trap.
- R13: At most one trap flag is high; the cause is 2 for illegal, 22 for virtual and 0 when neither is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr_i | input | 12 | CSR address of the access |
| csr_we_i | input | 1 | Access writes the CSR |
| prv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Virtualization mode active |
| m_se_i | input | WORD_W | Machine state-enable word 0 |
| h_se_i | input | WORD_W | Hypervisor state-enable word 0 |
| s_se_i | input | WORD_W | Supervisor state-enable word 0 |
| fp_ext_en_i | input | 1 | Floating-point extension enabled |
| sup_en_i | input | 1 | Supervisor mode implemented |
| se_ext_en_i | input | 1 | State-enable extension enabled |
| fp_in_int_en_i | input | 1 | FP-in-integer-registers extension enabled |
| illegal_o | output | 1 | Raise illegal-instruction exception |
| virtual_o | output | 1 | Raise virtual-instruction exception |
| cause_o | output | CAUSE_W | Exception cause code, 0 when no trap |

## Verification
The hardest situations to reach are those where more than one gate would fire at once. The first gate in the order must win even when a later gate, or the generic check, would give the other trap type. An example is a VU access to henvcfg with the machine bit clear: the generic check alone would give virtual, but the answer must be illegal. The stimulus therefore clears several enable words together with V set, so the machine, hypervisor and supervisor conditions fail in the same access. Other cases set every bit except the one under test, which shows that the decision depends only on the documented bit positions.

// File: rtl/csr_se_pkg.sv
package csr_se_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_H = 2'd2;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [11:0] A_FFLAGS    = 12'h001;
  localparam logic [11:0] A_FRM       = 12'h002;
  localparam logic [11:0] A_FCSR      = 12'h003;
  localparam logic [11:0] A_SENVCFG   = 12'h10A;
  localparam logic [11:0] A_HENVCFG   = 12'h60A;
  localparam logic [11:0] A_HSTATEEN0 = 12'h60C;

  typedef struct packed {
    logic fire;
    logic virt;
  } verdict_t;

  function automatic verdict_t first_of(verdict_t a, verdict_t b);
    return a.fire ? a : b;
  endfunction

  function automatic logic is_fp_csr(logic [11:0] a);
    return (a == A_FFLAGS) || (a == A_FRM) || (a == A_FCSR);
  endfunction
endpackage

// File: rtl/csr_fp_gate.sv
module csr_fp_gate
  import csr_se_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic [1:0]  prv_i,
  input  logic        virt_i,
  input  logic        m_bit_i,
  input  logic        h_bit_i,
  input  logic        s_bit_i,
  input  logic        fp_ext_en_i,
  input  logic        sup_en_i,
  input  logic        se_ext_en_i,
  input  logic        fp_in_int_en_i,
  output verdict_t    vd_o
);
  logic gated, m_miss, h_miss, s_miss;

  assign gated  = se_ext_en_i && fp_in_int_en_i;
  assign m_miss = (prv_i != PRV_M) && !m_bit_i;
  assign h_miss = virt_i && !h_bit_i;
  assign s_miss = sup_en_i && (prv_i == PRV_U) && !s_bit_i;

  always_comb begin
    vd_o = '0;
    if (is_fp_csr(addr_i)) begin
      if (!fp_ext_en_i) begin
        vd_o.fire = 1'b1;
      end else if (gated) begin
        if (m_miss) begin
          vd_o.fire = 1'b1;
        end else if (h_miss) begin
          vd_o.fire = 1'b1;
          vd_o.virt = 1'b1;
        end else if (s_miss) begin
          vd_o.fire = 1'b1;
          vd_o.virt = virt_i;
        end
      end
    end
  end
endmodule

// File: rtl/csr_env_gate.sv
module csr_env_gate
  import csr_se_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic [1:0]  prv_i,
  input  logic        virt_i,
  input  logic        m_env_i,
  input  logic        m_se0_i,
  input  logic        h_env_i,
  input  logic        se_ext_en_i,
  output verdict_t    vd_o
);
  logic below_m;

  assign below_m = (prv_i != PRV_M);

  always_comb begin
    vd_o = '0;
    unique case (addr_i)
      A_SENVCFG: begin
        if (se_ext_en_i) begin
          if (below_m && !m_env_i) begin
            vd_o.fire = 1'b1;
          end else if (virt_i && !h_env_i) begin
            vd_o.fire = 1'b1;
            vd_o.virt = 1'b1;
          end
        end
      end
      A_HENVCFG: begin
        if (se_ext_en_i && below_m && !m_env_i) vd_o.fire = 1'b1;
      end
      A_HSTATEEN0: begin
        if (below_m && !m_se0_i) vd_o.fire = 1'b1;
      end
      default: vd_o = '0;
    endcase
  end
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
  import csr_se_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic        we_i,
  input  logic [1:0]  prv_i,
  input  logic        virt_i,
  output verdict_t    vd_o
);
  logic [1:0] need;
  logic       ok, ro;

  assign need = addr_i[9:8];
  assign ro   = (addr_i[11:10] == 2'b11);

  always_comb begin
    if (need == PRV_H) ok = (prv_i == PRV_M) || ((prv_i == PRV_S) && !virt_i);
    else               ok = (prv_i >= need);
  end

  always_comb begin
    vd_o = '0;
    if (!ok) begin
      vd_o.fire = 1'b1;
      vd_o.virt = (need == PRV_H) && virt_i;
    end else if (we_i && ro) begin
      vd_o.fire = 1'b1;
    end
  end
endmodule

// File: rtl/csr_se_gate.sv
module csr_se_gate
  import csr_se_pkg::*;
#(
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned FCSR_BIT   = 1,
  parameter int unsigned ENVCFG_BIT = 62,
  parameter int unsigned SE0_BIT    = 63,
  parameter int unsigned CAUSE_W    = 6,
  parameter int unsigned CAUSE_ILL  = 2,
  parameter int unsigned CAUSE_VIRT = 22
) (
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_we_i,
  input  logic [1:0]         prv_i,
  input  logic               virt_i,
  input  logic [WORD_W-1:0]  m_se_i,
  input  logic [WORD_W-1:0]  h_se_i,
  input  logic [WORD_W-1:0]  s_se_i,
  input  logic               fp_ext_en_i,
  input  logic               sup_en_i,
  input  logic               se_ext_en_i,
  input  logic               fp_in_int_en_i,
  output logic               illegal_o,
  output logic               virtual_o,
  output logic [CAUSE_W-1:0] cause_o
);
  verdict_t fp_vd, env_vd, priv_vd, final_vd;
  logic     unused_se;

  assign unused_se = ^{m_se_i, h_se_i, s_se_i};

  csr_fp_gate u_fp (
    .addr_i         (csr_addr_i),
    .prv_i          (prv_i),
    .virt_i         (virt_i),
    .m_bit_i        (m_se_i[FCSR_BIT]),
    .h_bit_i        (h_se_i[FCSR_BIT]),
    .s_bit_i        (s_se_i[FCSR_BIT]),
    .fp_ext_en_i    (fp_ext_en_i),
    .sup_en_i       (sup_en_i),
    .se_ext_en_i    (se_ext_en_i),
    .fp_in_int_en_i (fp_in_int_en_i),
    .vd_o           (fp_vd)
  );

  csr_env_gate u_env (
    .addr_i      (csr_addr_i),
    .prv_i       (prv_i),
    .virt_i      (virt_i),
    .m_env_i     (m_se_i[ENVCFG_BIT]),
    .m_se0_i     (m_se_i[SE0_BIT]),
    .h_env_i     (h_se_i[ENVCFG_BIT]),
    .se_ext_en_i (se_ext_en_i),
    .vd_o        (env_vd)
  );

  csr_priv_gate u_priv (
    .addr_i (csr_addr_i),
    .we_i   (csr_we_i),
    .prv_i  (prv_i),
    .virt_i (virt_i),
    .vd_o   (priv_vd)
  );

  // state-enable gates ahead of the generic check
  assign final_vd  = first_of(fp_vd, first_of(env_vd, priv_vd));
  assign illegal_o = final_vd.fire && !final_vd.virt;
  assign virtual_o = final_vd.fire && final_vd.virt;

  always_comb begin
    if (virtual_o)      cause_o = CAUSE_W'(CAUSE_VIRT);
    else if (illegal_o) cause_o = CAUSE_W'(CAUSE_ILL);
    else                cause_o = '0;
  end

  always_comb begin
    // R13
    one_trap_chk: assert (!(illegal_o && virtual_o));
    // R13
    cause_map_chk: assert ((illegal_o || virtual_o) == (cause_o != '0));
    // R1
    no_fp_ext_chk: assert (!(is_fp_csr(csr_addr_i) && !fp_ext_en_i) || illegal_o);
    // R3
    fp_m_gate_chk: assert (!(is_fp_csr(csr_addr_i) && fp_ext_en_i && se_ext_en_i &&
                             fp_in_int_en_i && prv_i != PRV_M && !m_se_i[FCSR_BIT])
                           || illegal_o);
    // R9
    se0_first_chk: assert (!(csr_addr_i == A_HSTATEEN0 && prv_i != PRV_M &&
                             !m_se_i[SE0_BIT]) || illegal_o);
    // R11
    ro_write_chk: assert (!(csr_we_i && csr_addr_i[11:10] == 2'b11) ||
                          illegal_o || virtual_o);
    // R12
    m_no_virt_chk: assert (!(prv_i == PRV_M && !virt_i) || !virtual_o);
  end
endmodule

// File: tb/sim_csr_se_gate.sv
`timescale 1ns/1ps
module sim_csr_se_gate;
  localparam int W = 64;

  typedef struct packed {
    logic [11:0] addr;
    logic        we;
    logic [1:0]  prv;
    logic        v;
    logic [2:0]  m;    // {se0, envcfg, fcsr}
    logic [2:0]  h;
    logic [2:0]  s;
    logic [3:0]  en;   // {f, s, state-enable ext, fp-in-int}
    logic [1:0]  exp;  // 0 none, 1 illegal, 2 virtual
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    {12'h001,1'b0,2'd0,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd1,8'd1},  // R1
    {12'h003,1'b1,2'd3,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd1,8'd1},  // R1
    {12'h002,1'b0,2'd0,1'b0,3'b000,3'b000,3'b000,4'b1110,2'd0,8'd2},  // R2
    {12'h003,1'b0,2'd0,1'b0,3'b000,3'b000,3'b000,4'b1101,2'd0,8'd2},  // R2
    {12'h001,1'b0,2'd1,1'b0,3'b000,3'b111,3'b111,4'b1111,2'd1,8'd3},  // R3
    {12'h001,1'b0,2'd0,1'b1,3'b000,3'b000,3'b000,4'b1111,2'd1,8'd3},  // R3
    {12'h001,1'b1,2'd3,1'b0,3'b000,3'b000,3'b000,4'b1111,2'd0,8'd12}, // R12
    {12'h002,1'b0,2'd1,1'b1,3'b111,3'b000,3'b111,4'b1111,2'd2,8'd4},  // R4
    {12'h002,1'b0,2'd0,1'b1,3'b111,3'b000,3'b000,4'b1111,2'd2,8'd4},  // R4
    {12'h003,1'b0,2'd0,1'b0,3'b111,3'b111,3'b000,4'b1111,2'd1,8'd5},  // R5
    {12'h003,1'b0,2'd0,1'b1,3'b111,3'b111,3'b000,4'b1111,2'd2,8'd5},  // R5
    {12'h003,1'b0,2'd0,1'b0,3'b111,3'b111,3'b000,4'b1011,2'd0,8'd5},  // R5
    {12'h003,1'b0,2'd1,1'b1,3'b111,3'b111,3'b000,4'b1111,2'd0,8'd5},  // R5
    {12'h10A,1'b0,2'd1,1'b0,3'b000,3'b111,3'b000,4'b0010,2'd1,8'd6},  // R6
    {12'h10A,1'b0,2'd1,1'b1,3'b010,3'b000,3'b000,4'b0010,2'd2,8'd6},  // R6
    {12'h10A,1'b0,2'd1,1'b1,3'b010,3'b010,3'b000,4'b0010,2'd0,8'd6},  // R6
    {12'h10A,1'b0,2'd1,1'b1,3'b000,3'b000,3'b000,4'b0000,2'd0,8'd6},  // R6
    {12'h10A,1'b0,2'd0,1'b1,3'b010,3'b010,3'b000,4'b0010,2'd1,8'd10}, // R10
    {12'h60A,1'b0,2'd0,1'b1,3'b000,3'b111,3'b000,4'b0010,2'd1,8'd9},  // R9
    {12'h10A,1'b0,2'd0,1'b1,3'b000,3'b000,3'b000,4'b0010,2'd1,8'd9},  // R9
    {12'h60A,1'b0,2'd1,1'b0,3'b000,3'b000,3'b000,4'b0010,2'd1,8'd7},  // R7
    {12'h60A,1'b0,2'd1,1'b1,3'b010,3'b000,3'b000,4'b0010,2'd2,8'd7},  // R7
    {12'h60A,1'b0,2'd1,1'b0,3'b010,3'b000,3'b000,4'b0010,2'd0,8'd7},  // R7
    {12'h60C,1'b0,2'd0,1'b1,3'b000,3'b111,3'b000,4'b0000,2'd1,8'd8},  // R8
    {12'h60C,1'b0,2'd1,1'b0,3'b100,3'b000,3'b000,4'b0000,2'd0,8'd8},  // R8
    {12'h60C,1'b0,2'd1,1'b1,3'b100,3'b000,3'b000,4'b0000,2'd2,8'd10}, // R10
    {12'h60C,1'b1,2'd3,1'b0,3'b000,3'b000,3'b000,4'b0010,2'd0,8'd12}, // R12
    {12'h300,1'b0,2'd1,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd1,8'd10}, // R10
    {12'h300,1'b1,2'd3,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd0,8'd10}, // R10
    {12'h100,1'b0,2'd0,1'b1,3'b111,3'b111,3'b111,4'b0000,2'd1,8'd10}, // R10
    {12'h600,1'b0,2'd0,1'b1,3'b000,3'b000,3'b000,4'b0000,2'd2,8'd10}, // R10
    {12'hC00,1'b0,2'd0,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd0,8'd11}, // R11
    {12'hC00,1'b1,2'd0,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd1,8'd11}, // R11
    {12'hF11,1'b1,2'd3,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd1,8'd11}, // R11
    {12'hF11,1'b0,2'd3,1'b0,3'b000,3'b000,3'b000,4'b0000,2'd0,8'd11}  // R11
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [11:0]  addr = '0;
  logic         we = 1'b0;
  logic [1:0]   prv = 2'd0;
  logic         v = 1'b0;
  logic [W-1:0] mse = '0, hse = '0, sse = '0;
  logic         f_en = 1'b0, s_en = 1'b0, sm_en = 1'b0, zx_en = 1'b0;
  logic         ill, vir;
  logic [5:0]   cause;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  csr_se_gate u0 (
    .csr_addr_i     (addr),
    .csr_we_i       (we),
    .prv_i          (prv),
    .virt_i         (v),
    .m_se_i         (mse),
    .h_se_i         (hse),
    .s_se_i         (sse),
    .fp_ext_en_i    (f_en),
    .sup_en_i       (s_en),
    .se_ext_en_i    (sm_en),
    .fp_in_int_en_i (zx_en),
    .illegal_o      (ill),
    .virtual_o      (vir),
    .cause_o        (cause)
  );

  function automatic logic [W-1:0] spread(logic [2:0] b);
    logic [W-1:0] w = '0;
    w[1]  = b[0];
    w[62] = b[1];
    w[63] = b[2];
    return w;
  endfunction

  task automatic expect_out(input logic [1:0] exp, input string tag);
    logic       e_ill = (exp == 2'd1);
    logic       e_vir = (exp == 2'd2);
    logic [5:0] e_c   = e_vir ? 6'd22 : (e_ill ? 6'd2 : 6'd0);
    checks++;
    if (ill !== e_ill || vir !== e_vir || cause !== e_c) begin
      fails++;
      $display("FAIL %s addr=%h: actual ill=%b virt=%b cause=%0d expected ill=%b virt=%b cause=%0d",
               tag, addr, ill, vir, cause, e_ill, e_vir, e_c);
    end
    // R13
    checks++;
    if (ill && vir) begin
      fails++;
      $display("FAIL R13 addr=%h: actual both flags high expected at most one", addr);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic w, input logic [1:0] p,
                       input logic vv, input logic [W-1:0] m, input logic [W-1:0] h,
                       input logic [W-1:0] s, input logic [3:0] en,
                       input logic [1:0] exp, input string tag);
    @(posedge clk);
    addr = a; we = w; prv = p; v = vv; mse = m; hse = h; sse = s;
    {f_en, s_en, sm_en, zx_en} = en;
    @(negedge clk);
    expect_out(exp, tag);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out(2'd0, "R10 idle in reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].addr, VEC[i].we, VEC[i].prv, VEC[i].v, spread(VEC[i].m),
            spread(VEC[i].h), spread(VEC[i].s), VEC[i].en, VEC[i].exp,
            $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R3: every bit but FCSR set in the machine word
    apply(12'h001, 1'b0, 2'd1, 1'b0, ~(W'(1) << 1), '1, '1, 4'b1111, 2'd1, "R3 bitpos");
    // R4: only FCSR set in machine word, hyp word missing only FCSR
    apply(12'h002, 1'b0, 2'd1, 1'b1, W'(1) << 1, ~(W'(1) << 1), '1, 4'b1111, 2'd2, "R4 bitpos");
    // R5: all words fully set from VU
    apply(12'h003, 1'b1, 2'd0, 1'b1, '1, '1, '1, 4'b1111, 2'd0, "R5 all set");
    // R6: env bit only missing in hyp word
    apply(12'h10A, 1'b0, 2'd1, 1'b1, '1, ~(W'(1) << 62), '1, 4'b0010, 2'd2, "R6 bitpos");
    // R8: SE0 gate regardless of V and extension flag
    for (int p = 0; p < 2; p++) begin
      for (int vv = 0; vv < 2; vv++) begin
        apply(12'h60C, 1'b0, 2'(p), 1'(vv), ~(W'(1) << 63), '1, '1,
              4'(vv * 2), 2'd1, "R8 sweep");
      end
    end
    // R12: machine mode with nothing enabled in any word
    apply(12'h10A, 1'b1, 2'd3, 1'b0, '0, '0, '0, 4'b1111, 2'd0, "R12 senvcfg");
    apply(12'h60A, 1'b1, 2'd3, 1'b0, '0, '0, '0, 4'b1111, 2'd0, "R12 henvcfg");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule